// File: doc/BRIEF.md
# Oversampled Asynchronous Byte-Wide SRAM Emulator

This block stands in for a byte-wide asynchronous static RAM inside a synchronous design. A fast system clock samples three active-low controls (chip select, write enable and output enable) together with the address and the write data. The block turns them into one of four modes: deselected, write, read or selected with the outputs off. The bidirectional data bus is split into a data input, a data output and a drive-enable. A pad or a bus model outside the block combines them into a real three-state pin.

A write is not a clocked strobe. The word is stored when the sampled overlap of select-low and write-low ends, whichever of the two controls returns high first. The value stored is the data sampled one clock before the end of the overlap was seen, which models a data setup time. A read presents the word at the current sampled address straight from the array. The drive-enable is asserted only in the read mode.

The address width is a parameter. `ADDR_W = 15` gives the full 32768 x 8 array with address lines 0 to 14. The default of 11 elaborates a 2048-word slice that behaves the same way.

Top module: `async_sram_emu`

## Requirements
- R1: While the sampled select is high (deselected), `doe_o` is 0 whatever write enable and output enable are doing, and no word is written.
- R2: While sampled select and write enable are both low (write mode), `doe_o` is 0 whatever output enable is doing.
- R3: A write ended by write enable rising while select stays low stores the data at the address of that overlap.
- R4: A write ended by select rising while write enable stays low stores the data at the address of that overlap.
- R5: The stored byte is the data input sampled in the last clock of the overlap. A data change presented together with the rising control is not stored.
- R6: With sampled select low, write enable high and output enable low (read mode), `doe_o` is 1 and `dout_o` equals the stored word at the sampled address.
- R7: With sampled select low, write enable high and output enable high, `doe_o` is 0.
- R8: If write enable falls in the same sample as select, or before it, `doe_o` stays 0 for that whole access, even with output enable low.
- R9: Each input passes through a two-flop synchronizer. An input presented before clock edge k affects `doe_o` and `dout_o` only after edge k+1, and a write whose overlap end is sampled at edge k commits at edge k+2.
- R10: While `rst_n` is low, `doe_o` is 0.
- R11: A write-enable pulse while select is high changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n_i | input | 1 | Chip select, active low |
| wen_n_i | input | 1 | Write enable, active low |
| oen_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Data input half of the bus |
| dout_o | output | DATA_W | Data output half of the bus, the word at the sampled address |
| doe_o | output | 1 | Bus drive-enable, high only in read mode |

## Verification
The assertions count clock delays from the ports. They assume each input holds one value across every sampling edge, so the two synchronizer flops and the overlap register behave as a plain three-deep delay line. The stimulus changes the inputs one nanosecond after a rising edge, never between edges, and keeps the address steady for the whole of every write overlap. It also holds the block deselected with the address and data at zero for several cycles around reset. As a result, the values the assertions look back to after reset release are the values the reset loaded.

// File: rtl/async_sram_emu_pkg.sv
package async_sram_emu_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2,
    MODE_HIZ   = 2'd3
  } sram_mode_e;

  // Select outranks write enable, which outranks output enable.
  function automatic sram_mode_e decode_mode(input logic sel_n,
                                             input logic wen_n,
                                             input logic oen_n);
    sram_mode_e m;
    if (sel_n)       m = MODE_DESEL;
    else if (!wen_n) m = MODE_WRITE;
    else if (!oen_n) m = MODE_READ;
    else             m = MODE_HIZ;
    return m;
  endfunction
endpackage

// File: rtl/async_sram_emu_rst.sv
module async_sram_emu_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 100ps;

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/async_sram_emu_sync.sv
module async_sram_emu_sync #(
  parameter int             W       = 8,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_rest
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/async_sram_emu_ctrl.sv
module async_sram_emu_ctrl
  import async_sram_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              wen_n_s,
  input  logic              oen_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output sram_mode_e        mode_o,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic              ovl_now;
  logic              ovl_q;
  logic              ovl_d;
  logic              cap_en;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;

  // Next state: remember whether the previous sample was inside an overlap,
  // and keep the last address and data seen inside it.
  always_comb begin
    ovl_now = !sel_n_s && !wen_n_s;
    ovl_d   = ovl_now;
    cap_en  = ovl_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q      <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      ovl_q <= ovl_d;
      if (cap_en) begin
        cap_addr_q <= addr_s;
        cap_data_q <= din_s;
      end
    end
  end

  assign mode_o    = decode_mode(sel_n_s, wen_n_s, oen_n_s);
  assign wr_fire_o = ovl_q && !ovl_now;
  assign wr_addr_o = cap_addr_q;
  assign wr_data_o = cap_data_q;
endmodule

// File: rtl/async_sram_emu_array.sv
module async_sram_emu_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/async_sram_emu.sv
module async_sram_emu
  import async_sram_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              wen_n_i,
  input  logic              oen_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              doe_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int                SYNC_W   = 3 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic              rst_int_n;
  logic [SYNC_W-1:0] sync_q;
  logic              sel_n_s;
  logic              wen_n_s;
  logic              oen_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  sram_mode_e        mode;
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  async_sram_emu_rst u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  async_sram_emu_sync #(
    .W       (SYNC_W),
    .STAGES  (2),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({sel_n_i, wen_n_i, oen_n_i, addr_i, din_i}),
    .q_o   (sync_q)
  );

  assign {sel_n_s, wen_n_s, oen_n_s, addr_s, din_s} = sync_q;

  async_sram_emu_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_n_s   (sel_n_s),
    .wen_n_s   (wen_n_s),
    .oen_n_s   (oen_n_s),
    .addr_s    (addr_s),
    .din_s     (din_s),
    .mode_o    (mode),
    .wr_fire_o (wr_fire),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  async_sram_emu_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .we_i    (wr_fire),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (addr_s),
    .rdata_o (rd_data)
  );

  assign dout_o = rd_data;
  assign doe_o  = (mode == MODE_READ);
endmodule

// File: rtl/async_sram_emu_chk.sv
module async_sram_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_n_i,
  input logic wen_n_i,
  input logic oen_n_i,
  input logic doe_o,
  input logic wr_fire
);
  timeunit 1ns;
  timeprecision 100ps;

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n_i, 2) |-> !doe_o); // R1

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel_n_i, 2) && !$past(wen_n_i, 2)) |-> !doe_o); // R2

  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (!$past(sel_n_i, 3) && !$past(wen_n_i, 3)
                 && ($past(sel_n_i, 2) || $past(wen_n_i, 2)))); // R3

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel_n_i, 2) && $past(wen_n_i, 2) && !$past(oen_n_i, 2)) |-> doe_o); // R6

  AST_OE_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel_n_i, 2) && $past(wen_n_i, 2) && $past(oen_n_i, 2)) |-> !doe_o); // R7
endmodule

bind async_sram_emu async_sram_emu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n_i (sel_n_i),
  .wen_n_i (wen_n_i),
  .oen_n_i (oen_n_i),
  .doe_o   (doe_o),
  .wr_fire (wr_fire)
);

// File: tb/async_sram_emu_bench.sv
module async_sram_emu_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, wen_n, oen_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          doe;

  int n_chk = 0;
  int n_bad = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;
  bit seen_doe = 1'b0;

  always #2.5 clk = ~clk;

  async_sram_emu #(.ADDR_W(AW), .DATA_W(DW)) u_async_sram_emu (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_i (sel_n),
    .wen_n_i (wen_n),
    .oen_n_i (oen_n),
    .addr_i  (addr),
    .din_i   (din),
    .dout_o  (dout),
    .doe_o   (doe)
  );

  // Behavioural reference: a queue of input samples and a sparse memory.
  typedef struct { bit s; bit w; bit o; int a; int d; } snap_t;
  snap_t      hist[$];
  logic [7:0] ref_mem [int];
  bit         exp_doe;
  int         exp_a;
  string      exp_tag;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hist.push_back('{s:1, w:1, o:1, a:0, d:0});
  end

  always @(posedge clk) begin
    snap_t c2, c3, e;
    hist.push_back('{s:sel_n, w:wen_n, o:oen_n, a:int'(addr), d:int'(din)});
    if (hist.size() > 6) void'(hist.pop_front());
    c2 = hist[hist.size()-3];
    c3 = hist[hist.size()-4];
    // R3 R4 R5 R9: overlap ended one sample later, data from its last sample
    if (!c3.s && !c3.w && (c2.s || c2.w)) ref_mem[c3.a] = 8'(c3.d);
    e = hist[hist.size()-2];
    exp_doe = !e.s && e.w && !e.o;
    exp_a   = e.a;
    if (e.s)       exp_tag = "R1";
    else if (!e.w) exp_tag = "R2";
    else if (!e.o) exp_tag = "R6";
    else           exp_tag = "R7";
  end

  always @(negedge clk) begin
    if (doe) seen_doe = 1'b1;
    if (armed && rst_n) begin
      chk(doe == exp_doe, {exp_tag, " drive-enable (R9 latency)"}, int'(doe), int'(exp_doe));
      if (exp_doe && ref_mem.exists(exp_a))
        chk(dout == ref_mem[exp_a], "R6 read data", int'(dout), int'(ref_mem[exp_a]));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sel_n = 1'b1; wen_n = 1'b1; oen_n = 1'b1;
  endtask

  task automatic read_expect(input int a, input int exp, input string tag);
    sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b0; addr = AW'(a);
    tick(3);
    @(negedge clk);
    chk(doe == 1'b1 && int'(dout) == exp, tag, int'(dout), exp);
    tick(1);
    idle();
    tick(2);
  endtask

  task automatic write_by_wen(input int a, input int d);
    sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b1; addr = AW'(a); din = DW'(d);
    tick(1);
    wen_n = 1'b0;
    tick(2);
    wen_n = 1'b1;
    tick(1);
    idle();
    tick(3);
  endtask

  task automatic write_by_sel(input int a, input int d);
    sel_n = 1'b1; wen_n = 1'b0; oen_n = 1'b0; addr = AW'(a); din = DW'(d);
    tick(1);
    sel_n = 1'b0;
    tick(2);
    sel_n = 1'b1;
    tick(1);
    idle();
    tick(3);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    addr = '0;
    din  = '0;
    tick(4);
    @(negedge clk);
    chk(doe == 1'b0, "R10 drive-enable in reset", int'(doe), 0);
    tick(1);
    rst_n = 1'b1;
    tick(6);
    armed = 1'b1;

    // R3: write ended by write enable, then read back
    write_by_wen(5, 8'hA5);
    read_expect(5, 8'hA5, "R3 wen-ended write");

    // R4 and R8: write ended by select, write enable low first with oen low
    seen_doe = 1'b0;
    write_by_sel(9, 8'h3C);
    chk(seen_doe == 1'b0, "R8 wen before select keeps bus off", int'(seen_doe), 0);
    read_expect(9, 8'h3C, "R4 sel-ended write");

    // R8: both fall in the same sample with oen low
    seen_doe = 1'b0;
    sel_n = 1'b0; wen_n = 1'b0; oen_n = 1'b0; addr = AW'(12); din = 8'h77;
    tick(3);
    wen_n = 1'b1; sel_n = 1'b1;
    tick(3);
    chk(seen_doe == 1'b0, "R8 simultaneous fall keeps bus off", int'(seen_doe), 0);
    read_expect(12, 8'h77, "R4 simultaneous rise stores");

    // R5: new data presented together with the rising write enable is not stored
    sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b1; addr = AW'(20); din = 8'h11;
    tick(1);
    wen_n = 1'b0;
    tick(2);
    wen_n = 1'b1; din = 8'hEE;
    tick(1);
    idle();
    tick(3);
    read_expect(20, 8'h11, "R5 data from last overlap sample");

    // R11: write-enable pulse while deselected leaves the word alone
    sel_n = 1'b1; wen_n = 1'b0; addr = AW'(5); din = 8'h00;
    tick(3);
    idle();
    tick(3);
    read_expect(5, 8'hA5, "R11 deselected write ignored");

    // R7: selected, read direction, outputs off
    sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b1; addr = AW'(5);
    tick(3);
    @(negedge clk);
    chk(doe == 1'b0, "R7 oen high keeps bus off", int'(doe), 0);
    idle();
    tick(3);

    // R1: deselected with oen low
    sel_n = 1'b1; wen_n = 1'b1; oen_n = 1'b0; addr = AW'(5);
    tick(3);
    @(negedge clk);
    chk(doe == 1'b0, "R1 deselected keeps bus off", int'(doe), 0);
    idle();
    tick(3);

    // R9: drive-enable appears two edges after the read is presented
    sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b0; addr = AW'(9);
    @(negedge clk);
    @(negedge clk);
    chk(doe == 1'b0, "R9 not yet after first edge", int'(doe), 0);
    @(negedge clk);
    chk(doe == 1'b1, "R9 drive after second edge", int'(doe), 1);
    tick(1);
    idle();
    tick(3);

    // Mixed traffic on a few addresses, compared against the model every cycle
    for (int i = 0; i < 600; i++) begin
      sel_n = ($urandom_range(0, 3) == 0);
      wen_n = $urandom_range(0, 1) != 0;
      oen_n = $urandom_range(0, 1) != 0;
      if (sel_n || wen_n) addr = AW'($urandom_range(0, 7));
      din   = DW'($urandom);
      tick(1);
    end
    idle();
    tick(6);

    done = 1'b1;
    finish_run();
  end
endmodule